// File: doc/BRIEF.md
# Dual-Path Fault-Tolerant Router Crossbar

This block is the switching fabric of a five-port on-chip router. Every output can be reached over two independent switching planes: a primary plane and a spare one. Each cycle, a flit on any input is steered to the output named by its destination code. Inputs compete for an output on a fixed priority, and the winning flit leaves in the same cycle it arrives.

A fault-detection function outside the block raises one flag per plane per output. A registered route table inside the block turns those flags into the select fields that steer each input. The first-level selects pick the plane, the steering selects pick the lane, and a three-way select at each output picks the primary lane, the spare lane or nothing. When the primary plane of an output fails, traffic for that output moves to the spare plane from the next cycle on. When both planes of an output fail, the output is shut off and any flit aimed at it is reported as unreachable.

Allocation and fault detection are done elsewhere. This block only carries out the routes and reports the errors it can see at its own inputs.

Top module: `dpx_xbar`

## Requirements
- R1: While reset is held and in the first cycle after it, every output's route code on `out_route` is 0 (primary) and no output is valid when no input is valid.
- R2: Destination codes are 0 east, 1 west, 2 north, 3 south and 4 local. A valid flit on input i with destination d appears on output d in the same cycle, with identical data and `out_valid[d]` high. Several inputs may go to different outputs in the same cycle.
- R3: A valid flit whose destination code is 5 or more is dropped. `err_bad_dest` is high in that cycle, and no output carries it.
- R4: When two or more valid inputs target the same output in one cycle, `err_conflict` is high in that cycle and only the lowest-numbered of those inputs is delivered.
- R5: If the primary fault flag of output o is high while its spare flag is low, then from the next cycle `out_route[o]` reads 1 and flits for o are delivered unchanged over the spare plane.
- R6: If both fault flags of output o are high, then from the next cycle `out_route[o]` reads 2 and output o stays invalid with zero data. A valid flit aimed at o raises `err_unreach` in that cycle.
- R7: The route of an output follows the previous cycle's flags. With the primary flag low, the route reads 0 again, even if the spare flag alone is high.
- R8: Each output's route is kept on its own. Two outputs can run on their spare planes at the same time and both still deliver their flits.
- R9: An output that is not valid drives all-zero data, even when the inputs carry nonzero data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 5 | Flit present, one bit per input port |
| in_dest | input | 15 | Granted destination per input, 3 bits each, input i at bits [3i+2:3i] |
| in_data | input | 5*DATA_W | Flit data per input, input i at slice i |
| fault_pri | input | 5 | Primary plane to output o detected faulty |
| fault_sec | input | 5 | Spare plane to output o detected faulty |
| out_valid | output | 5 | Flit present per output port |
| out_data | output | 5*DATA_W | Flit data per output, output o at slice o |
| out_route | output | 10 | Output select per output, 2 bits each: 0 primary, 1 spare, 2 shut off |
| err_bad_dest | output | 1 | A valid input carried a destination code of 5 or more |
| err_conflict | output | 1 | Two or more valid inputs targeted one output |
| err_unreach | output | 1 | A valid input targeted an output whose planes have both failed |

## Verification
The hardest states to reach are the ones in which the route table has left the primary plane. Traffic can only be checked against them one cycle after the fault flags change. The stimulus therefore raises a flag pattern together with a flit, and the bench expects that first flit still on the old route. The flit in the following vector then shows the new route, the spare delivery or the silent output. The same two-step pattern covers the return to the primary plane, two outputs on their spare planes at once, and a spare-only fault that must not move the route.

// File: rtl/dpx_pkg.sv
// Shared constants and the route-code type for the dual-path crossbar.
package dpx_pkg;
    localparam int unsigned NPORT = 5;   // five-port router: E, W, N, S, local
    localparam int unsigned DST_W = 3;   // destination code width

    // Per-output select of the final 3:1 output stage
    typedef enum logic [1:0] {
        RT_PRI  = 2'd0,
        RT_SEC  = 2'd1,
        RT_DEAD = 2'd2
    } route_e;
endpackage

// File: rtl/dpx_req_decode.sv
// Request decoder: turns per-input destination codes into a per-output
// request matrix and a one-winner-per-output grant (lowest input wins).
// Flags out-of-range destinations and multiple requesters per output.
// Assumes destination codes at or above NP are illegal and drops them.
module dpx_req_decode #(
    parameter int unsigned NP = 5,
    parameter int unsigned DW = 3
) (
    input  logic [NP-1:0]          in_valid,
    input  logic [NP*DW-1:0]       in_dest,
    output logic [NP-1:0][NP-1:0]  grant,     // [output][input]
    output logic [NP-1:0]          any_req,
    output logic                   bad_dest,
    output logic                   conflict
);
    logic [NP-1:0][NP-1:0] req;
    logic [NP-1:0]         found;

    // Build the request matrix and flag illegal codes
    always_comb begin
        req      = '0;
        bad_dest = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (in_valid[i] && (in_dest[i*DW +: DW] >= DW'(NP)))
                bad_dest = 1'b1;
            for (int o = 0; o < NP; o++) begin
                if (in_valid[i] && (in_dest[i*DW +: DW] == DW'(o)))
                    req[o][i] = 1'b1;
            end
        end
    end

    // Fixed-priority pick per output, plus conflict detection
    always_comb begin
        grant    = '0;
        found    = '0;
        any_req  = '0;
        conflict = 1'b0;
        for (int o = 0; o < NP; o++) begin
            any_req[o] = |req[o];
            if ($countones(req[o]) > 1)
                conflict = 1'b1;
            for (int i = 0; i < NP; i++) begin
                if (req[o][i] && !found[o]) begin
                    grant[o][i] = 1'b1;
                    found[o]    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dpx_route_ctrl.sv
// Route controller: holds, per output, which plane carries its traffic.
// Updated every cycle from the fault flags, so a flag change takes effect
// on the next cycle. Assumes the flags are already filtered and stable.
module dpx_route_ctrl
    import dpx_pkg::*;
#(
    parameter int unsigned NP = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        fault_pri,
    input  logic [NP-1:0]        fault_sec,
    output logic [NP-1:0][1:0]   route_q
);
    // Rewrite each output's route code from its pair of fault flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else begin
            for (int o = 0; o < NP; o++) begin
                if (fault_pri[o] && fault_sec[o])
                    route_q[o] <= RT_DEAD;
                else if (fault_pri[o])
                    route_q[o] <= RT_SEC;
                else
                    route_q[o] <= RT_PRI;
            end
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_chk
        p_reset_pri_r1: assert property (@(posedge clk)
            !rst_n |=> route_q[o] == RT_PRI);
        p_move_spare_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_pri[o] && !fault_sec[o]) |=> route_q[o] == RT_SEC);
        p_shut_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_pri[o] && fault_sec[o]) |=> route_q[o] == RT_DEAD);
        p_return_pri_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !fault_pri[o] |=> route_q[o] == RT_PRI);
    end
endmodule

// File: rtl/dpx_plane.sv
// One switching plane. Each enabled input is steered by its one-hot lane
// select onto its output lane, and the lanes merge by OR.
// Assumes at most one enabled input per lane (grant is one-hot per output).
module dpx_plane #(
    parameter int unsigned NP     = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic [NP-1:0]          in_en,     // input uses this plane
    input  logic [NP-1:0][NP-1:0]  in_steer,  // [input][output] one-hot
    input  logic [NP*DATA_W-1:0]   in_data,
    output logic [NP-1:0]          lane_valid,
    output logic [NP*DATA_W-1:0]   lane_data
);
    // Steer each enabled input onto its lane and merge the lanes
    always_comb begin
        lane_valid = '0;
        lane_data  = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                if (in_en[i] && in_steer[i][o]) begin
                    lane_valid[o]              = 1'b1;
                    lane_data[o*DATA_W +: DATA_W] = lane_data[o*DATA_W +: DATA_W]
                                                 | in_data[i*DATA_W +: DATA_W];
                end
            end
        end
    end
endmodule

// File: rtl/dpx_out_mux.sv
// Final 3:1 output selection for one output: primary lane, spare lane,
// or nothing (shut off). An idle output drives zero data.
module dpx_out_mux
    import dpx_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              pri_valid,
    input  logic [DATA_W-1:0] pri_data,
    input  logic              sec_valid,
    input  logic [DATA_W-1:0] sec_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Pick the lane named by the route code
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        case (sel)
            RT_PRI: begin
                out_valid = pri_valid;
                out_data  = pri_valid ? pri_data : '0;
            end
            RT_SEC: begin
                out_valid = sec_valid;
                out_data  = sec_valid ? sec_data : '0;
            end
            default: begin
                out_valid = 1'b0;
                out_data  = '0;
            end
        endcase
    end

    p_dead_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RT_DEAD) |-> !out_valid);
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));
endmodule

// File: rtl/dpx_xbar.sv
// Five-port crossbar with a primary and a spare switching plane per output.
// Per input, the plane select (first level) and lane steering are derived
// from the grant and the registered route table. Per output, a 3:1 select
// picks the plane. Flits pass in the same cycle; route changes lag the
// fault flags by one cycle. Assumes fault flags come from an external
// detector and destination codes from an external allocator.
module dpx_xbar
    import dpx_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT-1:0]         in_valid,
    input  logic [NPORT*DST_W-1:0]   in_dest,
    input  logic [NPORT*DATA_W-1:0]  in_data,
    input  logic [NPORT-1:0]         fault_pri,
    input  logic [NPORT-1:0]         fault_sec,
    output logic [NPORT-1:0]         out_valid,
    output logic [NPORT*DATA_W-1:0]  out_data,
    output logic [NPORT*2-1:0]       out_route,
    output logic                     err_bad_dest,
    output logic                     err_conflict,
    output logic                     err_unreach
);
    localparam int unsigned NP     = NPORT;
    localparam int unsigned DW     = DST_W;
    localparam int unsigned PLANES = 2;

    logic [NP-1:0][NP-1:0]      grant;
    logic [NP-1:0]              any_req;
    logic [NP-1:0][1:0]         route;
    logic [NP-1:0]              pri_mask, sec_mask, dead_mask;
    logic [NP-1:0][NP-1:0]      steer;          // lane steering per input
    logic [PLANES-1:0][NP-1:0]  plane_en;       // first-level plane select
    logic [PLANES-1:0][NP-1:0]  pl_valid;
    logic [PLANES-1:0][NP*DATA_W-1:0] pl_data;

    dpx_req_decode #(.NP(NP), .DW(DW)) u_dec (
        .in_valid (in_valid),
        .in_dest  (in_dest),
        .grant    (grant),
        .any_req  (any_req),
        .bad_dest (err_bad_dest),
        .conflict (err_conflict)
    );

    dpx_route_ctrl #(.NP(NP)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_pri (fault_pri),
        .fault_sec (fault_sec),
        .route_q   (route)
    );

    // Split the route table into per-output plane masks
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            pri_mask[o]  = (route[o] == RT_PRI);
            sec_mask[o]  = (route[o] == RT_SEC);
            dead_mask[o] = (route[o] == RT_DEAD);
        end
    end

    // Derive per-input steering and plane select from grant and routes
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++)
                steer[i][o] = grant[o][i];
            plane_en[0][i] = |(steer[i] & pri_mask);
            plane_en[1][i] = |(steer[i] & sec_mask);
        end
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        dpx_plane #(.NP(NP), .DATA_W(DATA_W)) u_plane (
            .in_en      (plane_en[p]),
            .in_steer   (steer),
            .in_data    (in_data),
            .lane_valid (pl_valid[p]),
            .lane_data  (pl_data[p])
        );
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        dpx_out_mux #(.DATA_W(DATA_W)) u_omux (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (route[o]),
            .pri_valid (pl_valid[0][o]),
            .pri_data  (pl_data[0][o*DATA_W +: DATA_W]),
            .sec_valid (pl_valid[1][o]),
            .sec_data  (pl_data[1][o*DATA_W +: DATA_W]),
            .out_valid (out_valid[o]),
            .out_data  (out_data[o*DATA_W +: DATA_W])
        );
    end

    assign out_route   = route;
    assign err_unreach = |(any_req & dead_mask);

    // Independent request view used only by the checks below
    logic [NP-1:0][NP-1:0] hit;
    always_comb begin
        for (int o = 0; o < NP; o++)
            for (int i = 0; i < NP; i++)
                hit[o][i] = in_valid[i] && (in_dest[i*DW +: DW] == DW'(o));
    end

    for (genvar o = 0; o < NP; o++) begin : g_chk
        p_src_exists_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> (|hit[o]));
        p_conflict_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(hit[o]) > 1) |-> err_conflict);
        p_unreach_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((route[o] == RT_DEAD) && (|hit[o])) |-> (err_unreach && !out_valid[o]));
        p_route_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
            route[o] != 2'd3);
    end
endmodule

// File: tb/dpx_xbar_tb.sv
module dpx_xbar_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int NP = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     in_valid = '0;
    logic [NP*3-1:0]   in_dest = '0;
    logic [NP*W-1:0]   in_data = '0;
    logic [NP-1:0]     fault_pri = '0;
    logic [NP-1:0]     fault_sec = '0;
    logic [NP-1:0]     out_valid;
    logic [NP*W-1:0]   out_data;
    logic [NP*2-1:0]   out_route;
    logic              err_bad_dest, err_conflict, err_unreach;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpx_xbar #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .fault_pri(fault_pri), .fault_sec(fault_sec),
        .out_valid(out_valid), .out_data(out_data), .out_route(out_route),
        .err_bad_dest(err_bad_dest), .err_conflict(err_conflict),
        .err_unreach(err_unreach)
    );

    typedef struct {
        logic [NP-1:0]   v;
        logic [NP*W-1:0] d;
        logic [NP*2-1:0] r;
        logic            ebd, ecf, eur;
        string           tag;
    } exp_t;

    exp_t       sb[$];
    int         n_vec = 0;
    int         n_bad = 0;
    logic [1:0] mroute [NP];   // bench model of the route table

    // Driver: apply one vector per cycle and push its expected result
    task automatic apply(input logic [NP-1:0] v, input logic [NP*3-1:0] d,
                         input logic [NP-1:0] fp, input logic [NP-1:0] fs,
                         input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        in_valid  = v;
        in_dest   = d;
        fault_pri = fp;
        fault_sec = fs;
        for (int i = 0; i < NP; i++)
            in_data[i*W +: W] = 16'hA000 | 16'(n_vec * 8 + i);
        e.v = '0; e.d = '0; e.r = '0; e.ebd = 1'b0; e.ecf = 1'b0; e.eur = 1'b0;
        e.tag = tag;
        for (int i = 0; i < NP; i++)
            if (v[i] && d[i*3 +: 3] >= 3'd5) e.ebd = 1'b1;
        for (int o = 0; o < NP; o++) begin
            int cnt = 0;
            int win = -1;
            for (int i = 0; i < NP; i++)
                if (v[i] && d[i*3 +: 3] == 3'(o)) begin
                    cnt++;
                    if (win < 0) win = i;
                end
            e.r[o*2 +: 2] = mroute[o];
            if (cnt > 1) e.ecf = 1'b1;
            if (mroute[o] == 2'd2) begin
                if (cnt > 0) e.eur = 1'b1;
            end else if (win >= 0) begin
                e.v[o] = 1'b1;
                e.d[o*W +: W] = in_data[win*W +: W];
            end
        end
        for (int o = 0; o < NP; o++)
            mroute[o] = (fp[o] && fs[o]) ? 2'd2 : (fp[o] ? 2'd1 : 2'd0);
        sb.push_back(e);
        n_vec++;
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [NP*W-1:0] got, input logic [NP*W-1:0] exp);
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Monitor: pop and compare in the middle of the cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.tag, "out_valid",    {{(NP*W-NP){1'b0}}, out_valid}, {{(NP*W-NP){1'b0}}, e.v});
            cmp(e.tag, "out_data",     out_data, e.d);
            cmp(e.tag, "out_route",    {{(NP*W-NP*2){1'b0}}, out_route}, {{(NP*W-NP*2){1'b0}}, e.r});
            cmp(e.tag, "err_bad_dest", {{(NP*W-1){1'b0}}, err_bad_dest}, {{(NP*W-1){1'b0}}, e.ebd});
            cmp(e.tag, "err_conflict", {{(NP*W-1){1'b0}}, err_conflict}, {{(NP*W-1){1'b0}}, e.ecf});
            cmp(e.tag, "err_unreach",  {{(NP*W-1){1'b0}}, err_unreach}, {{(NP*W-1){1'b0}}, e.eur});
        end
    end

    // Destination word builder: input i gets code di
    function automatic logic [NP*3-1:0] dst(input int d0, input int d1,
                                            input int d2, input int d3, input int d4);
        return {3'(d4), 3'(d3), 3'(d2), 3'(d1), 3'(d0)};
    endfunction

    initial begin
        for (int o = 0; o < NP; o++) mroute[o] = 2'd0;
        repeat (3) @(posedge clk);
        // R1: route table reads primary while reset is held
        #1;
        if (out_route !== '0) begin
            n_bad++;
            $display("FAIL R1 route in reset: got %h expected %h", out_route, 10'h0);
        end
        n_vec++;
        rst_n = 1'b1;

        apply(5'b00000, dst(0,0,0,0,0), 5'b0, 5'b0, "R1 idle after reset");
        apply(5'b11111, dst(1,2,3,4,0), 5'b0, 5'b0, "R2 rotate");
        apply(5'b11111, dst(0,1,2,3,4), 5'b0, 5'b0, "R2 identity");
        apply(5'b10000, dst(0,0,0,0,0), 5'b0, 5'b0, "R2 local to east");
        apply(5'b00111, dst(3,5,7,0,0), 5'b0, 5'b0, "R3 bad dest dropped");
        apply(5'b11010, dst(0,2,0,2,0), 5'b0, 5'b0, "R4 conflict on north");
        apply(5'b00001, dst(1,0,0,0,0), 5'b00010, 5'b0, "R5 fault raised, old route");
        apply(5'b00101, dst(1,0,3,0,0), 5'b00010, 5'b0, "R5 spare delivery");
        apply(5'b01001, dst(1,0,0,1,0), 5'b01010, 5'b0, "R8 second fault raised");
        apply(5'b01001, dst(3,0,0,1,0), 5'b01010, 5'b0, "R8 two outputs on spare");
        apply(5'b00001, dst(1,0,0,0,0), 5'b00010, 5'b00010, "R6 both faults raised");
        apply(5'b01001, dst(1,0,0,4,0), 5'b00010, 5'b00010, "R6 output shut off");
        apply(5'b00001, dst(1,0,0,0,0), 5'b0, 5'b0, "R7 faults cleared, still off");
        apply(5'b00001, dst(1,0,0,0,0), 5'b0, 5'b0, "R7 primary restored");
        apply(5'b00010, dst(0,2,0,0,0), 5'b0, 5'b00100, "R7 spare-only fault");
        apply(5'b00010, dst(0,2,0,0,0), 5'b0, 5'b0, "R7 route stays primary");
        apply(5'b00000, dst(0,1,2,3,4), 5'b0, 5'b0, "R9 idle outputs zero");

        @(posedge clk);
        @(negedge clk);
        #1;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule